// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block decides which of the interrupt causes of a 16550-style serial port is reported to the host, and whether the interrupt line is raised at all. It keeps the interrupt-enable register and the pending flag for the "transmit holding register empty" cause. It compares both against the live receiver, transmitter and modem conditions that the rest of the port supplies. The outcome is an identification byte that the host reads, and a single level-sensitive interrupt request.

Five causes are ranked in a fixed order. When several are active at once, only the highest-ranked enabled one is reported. The data-available cause depends on the FIFO mode. With the FIFOs off, one waiting character is enough. With the FIFOs on, the receive count must reach the programmed trigger level. The transmitter-empty cause is a latched flag. The flag is set when the host enables interrupts while the holding register is empty, or when the transmitter reports that the holding register has drained. It is cleared when the host reads the identification register or writes a new character.

Top module: `uart_iid_top`

## Requirements
- R1: After reset the enable register reads 0, the identification byte reads 0x01 and the interrupt request is low.
- R2: A write to the enable register stores only the low 4 bits of the written byte. Bit 0 enables the receive causes (timeout and data available), bit 1 the transmitter-empty cause, bit 2 the line-status cause and bit 3 the modem cause. The stored value is visible on the clock edge that ends the write cycle.
- R3: With enable bit 2 set and any line-error input bit set (overrun, parity, framing or break), the identification low nibble is 0x6. This holds whatever other causes are active.
- R4: With enable bit 0 set and the character-timeout flag asserted, the low nibble is 0xC, unless a line-status cause is active. Timeout outranks data available.
- R5: With enable bit 0 set and data ready, the low nibble is 0x4 when no higher cause is active. In FIFO mode this also requires the receive count to be at or above the trigger level. In non-FIFO mode the count is ignored.
- R6: With enable bit 1 set and the transmitter-empty pending flag set, the low nibble is 0x2 when no higher cause is active. The flag is set by an enable-register write while the holding register is empty, or by a transmitter-drained pulse.
- R7: A read of the identification register or a write of the holding register clears the transmitter-empty pending flag. A clear takes precedence over a set in the same cycle.
- R8: With enable bit 3 set and any modem delta bit set, the low nibble is 0x0 when no other cause is active. This is the lowest rank.
- R9: The upper nibble of the identification byte is 0xC while the FIFOs are enabled and 0x0 otherwise.
- R10: The interrupt request is high exactly when the identification low nibble differs from 0x1. Both update together, one clock edge after the conditions that produce them.
- R11: A cause whose enable bit is clear never appears. With every enable bit clear, the byte stays 0x01 with the request low, whatever the status inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ien_wr | input | 1 | Host write strobe for the enable register |
| ien_wdata | input | 8 | Byte written to the enable register |
| hold_wr | input | 1 | Host write strobe for the transmit holding register |
| iid_rd | input | 1 | Host read strobe for the identification register |
| thr_empty | input | 1 | Transmit holding register is currently empty |
| txe_event | input | 1 | Pulse: holding register has just drained |
| ls_err | input | 4 | Line error bits: overrun, parity, framing, break |
| rx_ready | input | 1 | At least one received character is waiting |
| rx_timeout | input | 1 | Character-timeout pending flag |
| rx_count | input | CNT_W | Receive FIFO fill count |
| rx_trigger | input | CNT_W | Receive FIFO trigger level |
| fifo_on | input | 1 | FIFOs enabled |
| ms_delta | input | 4 | Modem status change bits |
| ien_value | output | 4 | Stored enable register |
| iid_value | output | 8 | Identification register value |
| irq | output | 1 | Interrupt request level |

## Verification
The checker assumes that the status inputs hold steady from one sampled edge to the next. It also assumes that a cleared transmitter-empty flag is not re-set in the cycle just after the clear. Both properties are judged one or two edges after the cause, so they rely on this assumption. The directed stimulus changes inputs only on falling edges. It lets several idle cycles pass before each comparison. It never combines an identification read with a set of the transmitter-empty flag in the following cycle.

// File: rtl/uart_iid_pkg.sv
package uart_iid_pkg;

   localparam int NUM_SRC = 5;

   // rank index: lower index wins
   localparam int SRC_LS   = 0;
   localparam int SRC_TO   = 1;
   localparam int SRC_RDA  = 2;
   localparam int SRC_THRE = 3;
   localparam int SRC_MS   = 4;

   typedef enum logic [3:0] {
      CODE_MS   = 4'h0,
      CODE_NONE = 4'h1,
      CODE_THRE = 4'h2,
      CODE_RDA  = 4'h4,
      CODE_LS   = 4'h6,
      CODE_TO   = 4'hC
   } iid_code_e;

   function automatic logic [3:0] src_code(input int idx);
      case (idx)
         SRC_LS:   return CODE_LS;
         SRC_TO:   return CODE_TO;
         SRC_RDA:  return CODE_RDA;
         SRC_THRE: return CODE_THRE;
         default:  return CODE_MS;
      endcase
   endfunction

endpackage

// File: rtl/iid_enable_reg.sv
module iid_enable_reg #(
   parameter int DATA_W = 8,
   parameter int EN_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              hold_wr,
   input  logic              iid_rd,
   input  logic              thr_empty,
   input  logic              txe_event,
   output logic [EN_W-1:0]   ien,
   output logic              txe_pend
);

   logic pend_clr;
   logic pend_set;

   assign pend_clr = hold_wr | iid_rd;
   assign pend_set = (wr & thr_empty) | txe_event;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ien      <= '0;
         txe_pend <= 1'b0;
      end else begin
         if (wr)
            ien <= wdata[EN_W-1:0];
         if (pend_clr)
            txe_pend <= 1'b0;
         else if (pend_set)
            txe_pend <= 1'b1;
      end
   end

endmodule

// File: rtl/iid_source_eval.sv
module iid_source_eval
   import uart_iid_pkg::*;
#(
   parameter int CNT_W = 5,
   parameter int EN_W  = 4
) (
   input  logic [EN_W-1:0]    ien,
   input  logic [3:0]         ls_err,
   input  logic               rx_ready,
   input  logic               rx_timeout,
   input  logic [CNT_W-1:0]   rx_count,
   input  logic [CNT_W-1:0]   rx_trigger,
   input  logic               fifo_on,
   input  logic               txe_pend,
   input  logic [3:0]         ms_delta,
   output logic [NUM_SRC-1:0] req
);

   localparam int EN_RX  = 0;
   localparam int EN_TX  = 1;
   localparam int EN_LS  = 2;
   localparam int EN_MS  = 3;

   logic level_met;

   assign level_met = !fifo_on || (rx_count >= rx_trigger);

   always_comb begin
      req           = '0;
      req[SRC_LS]   = ien[EN_LS] && (|ls_err);
      req[SRC_TO]   = ien[EN_RX] && rx_timeout;
      req[SRC_RDA]  = ien[EN_RX] && rx_ready && level_met;
      req[SRC_THRE] = ien[EN_TX] && txe_pend;
      req[SRC_MS]   = ien[EN_MS] && (|ms_delta);
   end

endmodule

// File: rtl/iid_prio_enc.sv
module iid_prio_enc
   import uart_iid_pkg::*;
#(
   parameter int N = NUM_SRC
) (
   input  logic [N-1:0] req,
   output logic [3:0]   code
);

   logic [N-1:0] grant;
   logic [3:0]   mask [N];

   genvar g;
   generate
      for (g = 0; g < N; g++) begin : g_rank
         if (g == 0) begin : g_top
            assign grant[g] = req[g];
         end else begin : g_low
            assign grant[g] = req[g] & ~(|req[g-1:0]);
         end
         assign mask[g] = grant[g] ? src_code(g) : 4'h0;
      end
   endgenerate

   always_comb begin
      code = 4'h0;
      for (int i = 0; i < N; i++)
         code = code | mask[i];
      if (req == '0)
         code = CODE_NONE;
   end

endmodule

// File: rtl/uart_iid_top.sv
module uart_iid_top
   import uart_iid_pkg::*;
#(
   parameter int CNT_W  = 5,
   parameter int DATA_W = 8,
   parameter int EN_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ien_wr,
   input  logic [DATA_W-1:0] ien_wdata,
   input  logic              hold_wr,
   input  logic              iid_rd,
   input  logic              thr_empty,
   input  logic              txe_event,
   input  logic [3:0]        ls_err,
   input  logic              rx_ready,
   input  logic              rx_timeout,
   input  logic [CNT_W-1:0]  rx_count,
   input  logic [CNT_W-1:0]  rx_trigger,
   input  logic              fifo_on,
   input  logic [3:0]        ms_delta,
   output logic [EN_W-1:0]   ien_value,
   output logic [7:0]        iid_value,
   output logic              irq
);

   localparam logic [3:0] FIFO_TAG = 4'hC;

   generate
      if (EN_W != 4) begin : g_bad_en
         $error("uart_iid_top: EN_W must be 4");
      end
      if (DATA_W < EN_W) begin : g_bad_data
         $error("uart_iid_top: DATA_W must cover EN_W");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("uart_iid_top: CNT_W must be at least 1");
      end
   endgenerate

   logic               txe_pend;
   logic [NUM_SRC-1:0] req;
   logic [3:0]         code_d;
   logic [3:0]         code_q;
   logic [3:0]         upper_q;
   logic               irq_q;

   iid_enable_reg #(.DATA_W(DATA_W), .EN_W(EN_W)) u_en (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (ien_wr),
      .wdata     (ien_wdata),
      .hold_wr   (hold_wr),
      .iid_rd    (iid_rd),
      .thr_empty (thr_empty),
      .txe_event (txe_event),
      .ien       (ien_value),
      .txe_pend  (txe_pend)
   );

   iid_source_eval #(.CNT_W(CNT_W), .EN_W(EN_W)) u_src (
      .ien        (ien_value),
      .ls_err     (ls_err),
      .rx_ready   (rx_ready),
      .rx_timeout (rx_timeout),
      .rx_count   (rx_count),
      .rx_trigger (rx_trigger),
      .fifo_on    (fifo_on),
      .txe_pend   (txe_pend),
      .ms_delta   (ms_delta),
      .req        (req)
   );

   iid_prio_enc #(.N(NUM_SRC)) u_enc (
      .req  (req),
      .code (code_d)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q  <= CODE_NONE;
         upper_q <= 4'h0;
         irq_q   <= 1'b0;
      end else begin
         code_q  <= code_d;
         upper_q <= fifo_on ? FIFO_TAG : 4'h0;
         irq_q   <= (code_d != CODE_NONE);
      end
   end

   assign iid_value = {upper_q, code_q};
   assign irq       = irq_q;

endmodule

// File: rtl/uart_iid_chk.sv
module uart_iid_chk #(
   parameter int CNT_W  = 5,
   parameter int DATA_W = 8,
   parameter int EN_W   = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ien_wr,
   input logic [DATA_W-1:0] ien_wdata,
   input logic              hold_wr,
   input logic              iid_rd,
   input logic              thr_empty,
   input logic              txe_event,
   input logic [3:0]        ls_err,
   input logic              rx_ready,
   input logic              rx_timeout,
   input logic [CNT_W-1:0]  rx_count,
   input logic [CNT_W-1:0]  rx_trigger,
   input logic              fifo_on,
   input logic [3:0]        ms_delta,
   input logic [EN_W-1:0]   ien_value,
   input logic [7:0]        iid_value,
   input logic              irq
);

   AST_IRQ_MATCHES_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      irq == (iid_value[3:0] != 4'h1)); // R10

   AST_ENABLE_LOW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      ien_wr |=> ien_value == $past(ien_wdata[EN_W-1:0])); // R2

   AST_LINE_STATUS_TOP: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_value[2] && (|ls_err)) |=> iid_value[3:0] == 4'h6); // R3

   AST_TXE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (iid_rd || hold_wr) ##1 (!ien_wr && !txe_event) |=> iid_value[3:0] != 4'h2); // R7

   AST_UPPER_NIBBLE: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> iid_value[7:4] == ($past(fifo_on) ? 4'hC : 4'h0)); // R9

   AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_value == '0) |=> !irq); // R11

endmodule

bind uart_iid_top uart_iid_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W), .EN_W(EN_W)) u_chk (.*);

// File: tb/sim_uart_iid_top.sv
module sim_uart_iid_top;

   localparam int CNT_W = 5;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ien_wr = 1'b0;
   logic [7:0]       ien_wdata = '0;
   logic             hold_wr = 1'b0;
   logic             iid_rd = 1'b0;
   logic             thr_empty = 1'b0;
   logic             txe_event = 1'b0;
   logic [3:0]       ls_err = '0;
   logic             rx_ready = 1'b0;
   logic             rx_timeout = 1'b0;
   logic [CNT_W-1:0] rx_count = '0;
   logic [CNT_W-1:0] rx_trigger = '0;
   logic             fifo_on = 1'b0;
   logic [3:0]       ms_delta = '0;
   logic [3:0]       ien_value;
   logic [7:0]       iid_value;
   logic             irq;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   uart_iid_top #(.CNT_W(CNT_W)) u0 (.*);

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic settle();
      repeat (3) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr_ien(input logic [7:0] v);
      @(negedge clk);
      ien_wr = 1'b1; ien_wdata = v;
      @(negedge clk);
      ien_wr = 1'b0;
   endtask

   task automatic pulse_rd();
      @(negedge clk); iid_rd = 1'b1;
      @(negedge clk); iid_rd = 1'b0;
   endtask

   task automatic pulse_hold();
      @(negedge clk); hold_wr = 1'b1;
      @(negedge clk); hold_wr = 1'b0;
   endtask

   task automatic pulse_txe();
      @(negedge clk); txe_event = 1'b1;
      @(negedge clk); txe_event = 1'b0;
   endtask

   task automatic clear_inputs();
      @(negedge clk);
      ls_err = '0; rx_ready = 0; rx_timeout = 0; rx_count = '0;
      rx_trigger = '0; fifo_on = 0; ms_delta = '0; thr_empty = 0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk("R1 enable", {4'h0, ien_value}, 8'h00);
      chk("R1 iid", iid_value, 8'h01);
      chk("R1 irq", {7'h0, irq}, 8'h00);
   endtask

   task automatic t_enable_write();
      wr_ien(8'hA5);
      chk("R2 low bits", {4'h0, ien_value}, 8'h05);
      wr_ien(8'hF0);
      chk("R2 high ignored", {4'h0, ien_value}, 8'h00);
   endtask

   task automatic t_masked();
      wr_ien(8'h00);
      thr_empty = 1; ls_err = 4'hF; rx_ready = 1; rx_timeout = 1; ms_delta = 4'hF;
      pulse_txe();
      settle();
      chk("R11 all masked iid", iid_value, 8'h01);
      chk("R11 all masked irq", {7'h0, irq}, 8'h00);
      pulse_hold();
      clear_inputs();
   endtask

   task automatic t_priority();
      wr_ien(8'h0F);
      ls_err = 4'h2; rx_timeout = 1; rx_ready = 1; ms_delta = 4'h1;
      settle();
      chk("R3 line status wins", iid_value, 8'h06);
      chk("R10 irq with cause", {7'h0, irq}, 8'h01);
      ls_err = 4'h0;
      settle();
      chk("R4 timeout over data", iid_value, 8'h0C);
      rx_timeout = 0;
      settle();
      chk("R5 non-fifo data ready", iid_value, 8'h04);
      pulse_txe();
      rx_ready = 0;
      settle();
      chk("R6 txe over modem", iid_value, 8'h02);
      pulse_rd();
      settle();
      chk("R8 modem after txe cleared", iid_value, 8'h00);
      chk("R10 irq for modem code", {7'h0, irq}, 8'h01);
      ms_delta = 4'h0;
      settle();
      chk("R10 idle iid", iid_value, 8'h01);
      chk("R10 idle irq", {7'h0, irq}, 8'h00);
      clear_inputs();
   endtask

   task automatic t_txe_flag();
      wr_ien(8'h00);
      thr_empty = 1;
      wr_ien(8'h02);
      settle();
      chk("R6 set by enable write", iid_value, 8'h02);
      pulse_rd();
      settle();
      chk("R7 cleared by iid read", iid_value, 8'h01);
      pulse_txe();
      settle();
      chk("R6 set by drain pulse", iid_value, 8'h02);
      pulse_hold();
      settle();
      chk("R7 cleared by holding write", iid_value, 8'h01);
      @(negedge clk); txe_event = 1; hold_wr = 1;
      @(negedge clk); txe_event = 0; hold_wr = 0;
      settle();
      chk("R7 clear beats set", iid_value, 8'h01);
      clear_inputs();
   endtask

   task automatic t_fifo();
      wr_ien(8'h01);
      fifo_on = 1; rx_trigger = 5'd8; rx_count = 5'd7; rx_ready = 1;
      settle();
      chk("R5 below trigger", iid_value, 8'hC1);
      chk("R9 fifo tag", {4'h0, iid_value[7:4]}, 8'h0C);
      rx_count = 5'd8;
      settle();
      chk("R5 at trigger", iid_value, 8'hC4);
      rx_count = 5'd14; rx_ready = 0;
      settle();
      chk("R5 no data ready", iid_value, 8'hC1);
      fifo_on = 0; rx_ready = 1; rx_count = 5'd0;
      settle();
      chk("R5 non-fifo ignores count", iid_value, 8'h04);
      chk("R9 tag drops", {4'h0, iid_value[7:4]}, 8'h00);
      clear_inputs();
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_enable_write();
      t_masked();
      t_priority();
      t_txe_flag();
      t_fifo();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #400000;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule